// File: doc/BRIEF.md
# CAN Controller Mode and Status Unit

This unit decides which operating mode a CAN controller is in (initialisation, sleep or normal) and reports it through a pair of word-wide registers on a simple register bus. Software writes request bits into the control word. A four-state machine moves the controller between modes, and the status word reports which mode has actually been reached.

A sleep request is not acted on at once. If a frame is being sent or received, the controller waits in a pending state and enters sleep only once the transfer has ended. While asleep, a dominant (low) level on the synchronised receive line counts as bus activity. Bus activity sets a wakeup flag. When automatic wakeup is enabled, bus activity also clears the sleep request in hardware, so the controller returns to normal mode without software.

Three flags (sleep entry, wakeup and error) are latched and cleared by writing 1 to them. The status word also shows the current and previous receive-line samples and whether a transmission or a reception is in progress. Three configuration bits from the control word are driven out to the frame logic that uses them.

The states are `MS_INIT`, `MS_SLEEP`, `MS_NORMAL` and `MS_SLEEP_PEND`. The transitions are:
- any state → `MS_INIT` when the init request is set;
- `MS_INIT` → `MS_SLEEP` when the init request is cleared with the sleep request set;
- `MS_INIT` → `MS_NORMAL` when both requests are cleared;
- `MS_NORMAL` → `MS_SLEEP_PEND` on a sleep request;
- `MS_SLEEP_PEND` → `MS_SLEEP` once no transfer is active;
- `MS_SLEEP_PEND` → `MS_NORMAL` if the sleep request is withdrawn;
- `MS_SLEEP` → `MS_NORMAL` when the sleep request is cleared, by software or by automatic wakeup.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the status word (address 1) reads 0x00000C02, the control word (address 0) reads 0x00000002 (sleep request set), and all three configuration outputs are 0.
- R2: Control bit 2 drives `tx_fifo_order`, bit 3 drives `rxq_discard` and bit 4 drives `retx_off`. Each output follows its bit on the cycle after the write. Bit 5 enables automatic wakeup. Control bits 5:0 read back as written.
- R3: While control bit 0 (init request) is set, the controller enters initialisation mode on the next cycle, even if bit 1 (sleep request) is also set. Status bit 0 is 1 only in initialisation mode.
- R4: A sleep request made in normal mode is deferred while `tx_active` or `rx_active` is high, and status bits 1:0 read 00 during that time. Sleep is entered on the first cycle after both are low.
- R5: Clearing the init request with the sleep request set moves the controller from initialisation directly to sleep. Clearing the sleep request by software moves it from sleep to normal, where status bits 1:0 read 00.
- R6: With automatic wakeup enabled, bus activity while asleep clears control bit 1 in hardware, and the controller is in normal mode on the next cycle.
- R7: With automatic wakeup disabled, bus activity while asleep sets the wakeup flag, but control bit 1 stays set and the controller stays asleep.
- R8: Status bits 4:2 (bit 2 sleep flag, bit 3 wakeup flag, bit 4 error flag) are cleared by writing 1. Writing 0 leaves them unchanged. A set event in the same cycle as a clear wins.
- R9: The sleep flag is set on the cycle sleep is entered. The error flag is set on the cycle after an `err_pulse`.
- R10: Status bit 11 shows the current synchronised receive level and bit 10 the previous sample. Bit 8 follows `tx_active` and bit 9 follows `rx_active`. Bits 31:12 and 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 1 | Word select: 0 control, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tx_active | input | 1 | A frame is being transmitted |
| rx_active | input | 1 | A frame is being received |
| err_pulse | input | 1 | One-cycle error event |
| can_rx | input | 1 | Raw receive line, asynchronous |
| retx_off | output | 1 | Automatic retransmission disabled |
| rxq_discard | output | 1 | Drop incoming frames when the receive queue is full |
| tx_fifo_order | output | 1 | 1: transmit in arrival order, 0: by identifier |

## Verification
A control write lands on the write edge, so configuration outputs and control read-back are checked at the negative edge right after it. A mode change appears one edge later, because the state machine reads the registered request bits. A change on `can_rx` reaches status bit 11 after two edges; the wakeup flag and the automatic clear of the sleep request follow on the third edge, and normal mode on the fourth. The bench drives inputs at negative edges, advances with whole-cycle steps, and samples only after the number of edges named above has passed, so each check lands exactly on the first cycle its result is due.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MS_INIT       = 2'd0,
        MS_SLEEP      = 2'd1,
        MS_NORMAL     = 2'd2,
        MS_SLEEP_PEND = 2'd3
    } mode_e;

    // control word fields
    localparam int CTL_INIT     = 0;
    localparam int CTL_SLEEP    = 1;
    localparam int CTL_TXORD    = 2;
    localparam int CTL_DISCARD  = 3;
    localparam int CTL_RETXOFF  = 4;
    localparam int CTL_AUTOWAKE = 5;
    localparam int CTL_BITS     = 6;

    // status word fields
    localparam int ST_INIT   = 0;
    localparam int ST_SLEEP  = 1;
    localparam int ST_FLAG0  = 2;   // sleep, wakeup, error flags at 2,3,4
    localparam int ST_TXING  = 8;
    localparam int ST_RXING  = 9;
    localparam int ST_LAST   = 10;
    localparam int ST_LEVEL  = 11;

    localparam int FLAG_N     = 3;
    localparam int FLAG_SLEEP = 0;
    localparam int FLAG_WAKE  = 1;
    localparam int FLAG_ERR   = 2;

    localparam logic [CTL_BITS-1:0] CTL_RESET = 6'b000010;

endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic last
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
            last_q  <= 1'b1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], pin};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign level = shift_q[STAGES-1];
    assign last  = last_q;
endmodule

// File: rtl/can_ctl_reg.sv
module can_ctl_reg
    import can_mode_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTL_BITS-1:0] wr_data,
    input  logic                hw_clr_sleep,
    output logic [CTL_BITS-1:0] ctl
);
    logic [CTL_BITS-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr_en) begin
            ctl_q <= wr_data;           // software write wins over hardware clear
        end else if (hw_clr_sleep) begin
            ctl_q[CTL_SLEEP] <= 1'b0;
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_req,
    input  logic  sleep_req,
    input  logic  busy,
    output mode_e mode,
    output logic  in_init,
    output logic  in_sleep,
    output logic  enter_sleep
);
    mode_e mode_q;
    mode_e mode_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MS_SLEEP;
        end else begin
            mode_q <= mode_nxt;
        end
    end

    // transitions
    always_comb begin
        mode_nxt = mode_q;
        unique case (mode_q)
            MS_INIT: begin
                if (init_req)       mode_nxt = MS_INIT;
                else if (sleep_req) mode_nxt = MS_SLEEP;
                else                mode_nxt = MS_NORMAL;
            end
            MS_SLEEP: begin
                if (init_req)        mode_nxt = MS_INIT;
                else if (!sleep_req) mode_nxt = MS_NORMAL;
                else                 mode_nxt = MS_SLEEP;
            end
            MS_NORMAL: begin
                if (init_req)       mode_nxt = MS_INIT;
                else if (sleep_req) mode_nxt = MS_SLEEP_PEND;
                else                mode_nxt = MS_NORMAL;
            end
            MS_SLEEP_PEND: begin
                if (init_req)        mode_nxt = MS_INIT;
                else if (!sleep_req) mode_nxt = MS_NORMAL;
                else if (!busy)      mode_nxt = MS_SLEEP;
                else                 mode_nxt = MS_SLEEP_PEND;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_init     = (mode_q == MS_INIT);
        in_sleep    = (mode_q == MS_SLEEP);
        enter_sleep = (mode_nxt == MS_SLEEP) && (mode_q != MS_SLEEP);
    end

    assign mode = mode_q;
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= set[i] | (flag_q & ~clr[i]);
            end
        end
        assign flags[i] = flag_q;
    end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic              err_pulse,
    input  logic              can_rx,
    output logic              retx_off,
    output logic              rxq_discard,
    output logic              tx_fifo_order
);
    localparam logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

    logic                ctl_wr;
    logic                stat_wr;
    logic [CTL_BITS-1:0] ctl;
    logic                rx_level;
    logic                rx_last;
    mode_e               mode_q;
    logic                in_init;
    logic                in_sleep;
    logic                enter_sleep;
    logic                wake_evt;
    logic                hw_clr_sleep;
    logic [FLAG_N-1:0]   flag_set;
    logic [FLAG_N-1:0]   flag_clr;
    logic [FLAG_N-1:0]   flags;
    logic                unused_wdata;

    assign ctl_wr  = bus_sel && bus_we && (bus_addr == ADDR_CTL);
    assign stat_wr = bus_sel && bus_we && (bus_addr == ADDR_STAT);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CTL_BITS];

    can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (can_rx),
        .level (rx_level),
        .last  (rx_last)
    );

    can_ctl_reg u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctl_wr),
        .wr_data      (bus_wdata[CTL_BITS-1:0]),
        .hw_clr_sleep (hw_clr_sleep),
        .ctl          (ctl)
    );

    can_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req    (ctl[CTL_INIT]),
        .sleep_req   (ctl[CTL_SLEEP]),
        .busy        (tx_active | rx_active),
        .mode        (mode_q),
        .in_init     (in_init),
        .in_sleep    (in_sleep),
        .enter_sleep (enter_sleep)
    );

    // bus activity is a dominant level seen while asleep
    assign wake_evt     = in_sleep && !rx_level;
    assign hw_clr_sleep = wake_evt && ctl[CTL_AUTOWAKE];

    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_SLEEP] = enter_sleep;
        flag_set[FLAG_WAKE]  = wake_evt;
        flag_set[FLAG_ERR]   = err_pulse;
        flag_clr = stat_wr ? bus_wdata[ST_FLAG0 +: FLAG_N] : '0;
    end

    can_irq_flags #(.N(FLAG_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTL) begin
            bus_rdata[CTL_BITS-1:0] = ctl;
        end else if (bus_addr == ADDR_STAT) begin
            bus_rdata[ST_INIT]               = in_init;
            bus_rdata[ST_SLEEP]              = in_sleep;
            bus_rdata[ST_FLAG0 +: FLAG_N]    = flags;
            bus_rdata[ST_TXING]              = tx_active;
            bus_rdata[ST_RXING]              = rx_active;
            bus_rdata[ST_LAST]               = rx_last;
            bus_rdata[ST_LEVEL]              = rx_level;
        end
    end

    assign retx_off      = ctl[CTL_RETXOFF];
    assign rxq_discard   = ctl[CTL_DISCARD];
    assign tx_fifo_order = ctl[CTL_TXORD];
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk
    import can_mode_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input mode_e mode,
    input logic  init_req,
    input logic  sleep_req,
    input logic  auto_wake,
    input logic  busy,
    input logic  rx_level,
    input logic  ctl_wr,
    input logic  err_pulse,
    input logic  sleep_flag,
    input logic  err_flag
);
    AST_INIT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (mode == MS_INIT)); // R3

    AST_NO_SLEEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MS_SLEEP_PEND && busy) |=> (mode != MS_SLEEP)); // R4

    AST_AUTO_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MS_SLEEP && auto_wake && !rx_level && !ctl_wr) |=> !sleep_req); // R6

    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MS_SLEEP && sleep_req && !init_req && !auto_wake && !ctl_wr)
        |=> (mode == MS_SLEEP)); // R7

    AST_SLEEP_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MS_SLEEP && $past(mode) != MS_SLEEP) |-> sleep_flag); // R9

    AST_ERR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> err_flag); // R9
endmodule

bind can_mode_ctrl can_mode_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .init_req   (ctl[0]),
    .sleep_req  (ctl[1]),
    .auto_wake  (ctl[5]),
    .busy       (tx_active | rx_active),
    .rx_level   (rx_level),
    .ctl_wr     (ctl_wr),
    .err_pulse  (err_pulse),
    .sleep_flag (flags[0]),
    .err_flag   (flags[2])
);

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [0:0]  bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_active = 1'b0, rx_active = 1'b0, err_pulse = 1'b0, can_rx = 1'b1;
    logic        retx_off, rxq_discard, tx_fifo_order;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    can_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_active(tx_active), .rx_active(rx_active), .err_pulse(err_pulse),
        .can_rx(can_rx), .retx_off(retx_off), .rxq_discard(rxq_discard),
        .tx_fifo_order(tx_fifo_order)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negative edge; returns at the negative edge after the write edge
    task automatic wr(input logic a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] stat_exp(input logic ini, input logic slp,
        input logic [2:0] fl, input logic tx, input logic rx,
        input logic last, input logic lvl);
        stat_exp = {20'd0, lvl, last, rx, tx, 3'd0, fl, slp, ini};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [3:0]  cfg;
        logic [2:0]  fl;
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset values
        rd(1, r); chk("R1 status", r, 32'h0000_0C02);
        rd(0, r); chk("R1 control", r, 32'h0000_0002);
        chk("R1 cfg outs", {29'd0, retx_off, rxq_discard, tx_fifo_order}, 32'd0);

        // R3 init wins over sleep
        wr(0, 32'h3); tick(1);
        rd(1, r); chk("R3 init priority", r, 32'h0000_0C01);
        tick(2);
        rd(1, r); chk("R3 init held", r, 32'h0000_0C01);

        // R5 init -> sleep directly, R9 sleep flag on entry
        wr(0, 32'h2); tick(1);
        rd(1, r); chk("R5/R9 init to sleep", r, 32'h0000_0C06);

        // R8 write 0 no effect, then clear
        wr(1, 32'h0);
        rd(1, r); chk("R8 write zero", r, 32'h0000_0C06);
        wr(1, 32'h4);
        rd(1, r); chk("R8 clear sleep flag", r, 32'h0000_0C02);

        // R5 software leaves sleep
        wr(0, 32'h0); tick(1);
        rd(1, r); chk("R5 sleep to normal", r, 32'h0000_0C00);

        // R4 deferred sleep
        tx_active = 1'b1;
        wr(0, 32'h2); tick(4);
        rd(1, r); chk("R4 pending tx", r, 32'h0000_0D00);
        rd(0, r); chk("R4 request kept", r, 32'h0000_0002);
        tx_active = 1'b0; rx_active = 1'b1; tick(1);
        rd(1, r); chk("R4 pending rx", r, 32'h0000_0E00);
        rx_active = 1'b0; tick(1);
        rd(1, r); chk("R4 sleep after idle", r, 32'h0000_0C06);
        wr(1, 32'h1C);

        // R7 wake without auto wakeup, R10 level bits
        can_rx = 1'b0; tick(2);
        rd(1, r); chk("R10 level low", r, 32'h0000_0402);
        tick(1);
        rd(1, r); chk("R7 wake flag", r, 32'h0000_000A);
        tick(2);
        rd(1, r); chk("R7 still asleep", r, 32'h0000_000A);
        rd(0, r); chk("R7 request kept", r, 32'h0000_0002);
        can_rx = 1'b1; tick(3);
        rd(1, r); chk("R10 level back", r, 32'h0000_0C0A);
        wr(1, 32'h8);
        rd(1, r); chk("R8 clear wake", r, 32'h0000_0C02);

        // R6 automatic wakeup
        wr(0, 32'h22); tick(1);
        can_rx = 1'b0; tick(2);
        rd(1, r); chk("R6 level low", r, 32'h0000_0402);
        tick(1);
        rd(0, r); chk("R6 hw clears request", r, 32'h0000_0020);
        rd(1, r); chk("R6 flag, still asleep", r, 32'h0000_000A);
        tick(1);
        rd(1, r); chk("R6 normal", r, 32'h0000_0008);
        can_rx = 1'b1; tick(3);
        wr(1, 32'h8);

        // R9 error flag, R8 set beats clear
        err_pulse = 1'b1; tick(1); err_pulse = 1'b0;
        rd(1, r); chk("R9 error flag", r, 32'h0000_0C10);
        err_pulse = 1'b1; wr(1, 32'h10); err_pulse = 1'b0;
        rd(1, r); chk("R8 set wins", r, 32'h0000_0C10);
        wr(1, 32'hFFFF_F010);
        rd(1, r); chk("R10 upper zero", r, 32'h0000_0C00);

        // R2 directed
        wr(0, 32'h1C);
        chk("R2 all cfg", {29'd0, retx_off, rxq_discard, tx_fifo_order}, 32'h7);

        // random phase in normal mode
        fl = 3'd0;
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom % 3;
            if (op == 0) begin
                cfg = 4'($urandom);
                wr(0, {26'd0, cfg, 2'b00});
                chk("R2 random cfg",
                    {29'd0, retx_off, rxq_discard, tx_fifo_order}, {29'd0, cfg[2:0]});
                rd(0, r); chk("R2 readback", r, {26'd0, cfg, 2'b00});
            end else if (op == 1) begin
                logic e;
                logic [2:0] m;
                e = 1'($urandom);
                m = 3'($urandom);
                err_pulse = e;
                wr(1, {27'd0, m, 2'b00});
                err_pulse = 1'b0;
                fl = (fl & ~m) | {e, 2'b00};
                rd(1, r); chk("R8/R9 random flags", r,
                              stat_exp(1'b0, 1'b0, fl, 1'b0, 1'b0, 1'b1, 1'b1));
            end else begin
                tx_active = 1'($urandom);
                rx_active = 1'($urandom);
                rd(1, r); chk("R10 busy bits", r,
                              stat_exp(1'b0, 1'b0, fl, tx_active, rx_active, 1'b1, 1'b1));
                tick(1);
                tx_active = 1'b0; rx_active = 1'b0;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule